// File: doc/BRIEF.md
# Banking Memory Unit Configuration Register File

This block is the byte-wide register file of a banking memory unit attached to an 8-bit CPU. It holds the active configuration byte, four preset configuration bytes, a mode byte, a RAM configuration byte and a fixed version byte. Downstream mapping logic uses the configuration byte to pick, for each address region, between RAM and the various ROMs. The mode and RAM configuration bytes are decoded into separate outputs for that logic as well.

The CPU reaches the registers through two windows, each with its own chip select. One is a full window in the I/O page. The other is a small window near the top of memory that is always visible. Both windows reach the same active configuration byte. In the small window, offsets 1 to 4 are load slots. A read of a load slot returns one preset. A write to a load slot copies that preset into the active byte, and the written data is discarded. Software can therefore switch the whole memory map with a single store.

A compatibility bit in the mode byte turns off decoding in both windows. Only a reset restores decoding.

Top module: `bankcfg_regs`

## Requirements
- R1: After reset the registers hold these values: active configuration byte 8'h00, presets 8'h3F, 8'h7F, 8'h01 and 8'h41 (I/O offsets 1 to 4), mode byte 8'hBF, RAM configuration byte 8'h00.
- R2: Offset 0 of the I/O window and offset 0 of the high window both read and write the same active configuration byte. A write takes effect at the clock edge where wr_en is high.
- R3: I/O offsets 1 to 4 read and write presets 0 to 3.
- R4: In the high window, a read of offset k (k = 1..4) returns preset k-1. A write to offset k copies preset k-1 into the active configuration byte, ignores the write data, and leaves the presets unchanged.
- R5: The mode byte sits at I/O offset 5. Bits 2:1 always read as 1. Bits 6..3 and bit 0 read back as written. cpu_alt_req is the inverse of bit 0. ext_a is bit 5, ext_b is bit 4 and fs_dir is bit 3.
- R6: While mode bit 6 is set, compat is 1. Both windows then ignore writes, and reads through either window return 8'h00.
- R7: Mode bit 7 reads as key_in AND the last value written to bit 7. After a write of 0 to bit 7, it reads as 0 whatever key_in is.
- R8: I/O offset 11 is read-only and returns 8'h20.
- R9: I/O offsets 7 to 10 and 12 to 255 read as 8'hFF and ignore writes.
- R10: The RAM configuration byte at I/O offset 6 reads back as written. Its bits drive these outputs: 7:6 video_bank, 5:4 ram_block, 3 share_top, 2 share_bottom, 1:0 share_size.
- R11: The active configuration byte drives these outputs: bits 7:6 ram_bank, 5:4 hi_area, 3:2 mid_area, 1 lo_area, 0 io_off.
- R12: rdata is 8'h00 in three cases: rd_en is low, no window is selected, or a high-window offset above 4 is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register offset within the selected window |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| io_sel | input | 1 | Select for the I/O window |
| hi_sel | input | 1 | Select for the high window |
| key_in | input | 1 | External key level (1 = released) |
| rdata | output | 8 | Read data (combinational) |
| ram_bank | output | 2 | RAM bank field of the active byte |
| hi_area | output | 2 | High region source code |
| mid_area | output | 2 | Middle region source code |
| lo_area | output | 1 | Low region source bit |
| io_off | output | 1 | I/O region disabled |
| compat | output | 1 | Compatibility mode active |
| cpu_alt_req | output | 1 | Request for the second CPU |
| ext_a | output | 1 | Mode bit 5 |
| ext_b | output | 1 | Mode bit 4 |
| fs_dir | output | 1 | Fast serial direction, mode bit 3 |
| video_bank | output | 2 | Video bank select |
| ram_block | output | 2 | RAM block select |
| share_top | output | 1 | Shared RAM placed at top |
| share_bottom | output | 1 | Shared RAM placed at bottom |
| share_size | output | 2 | Shared RAM size code |

## Verification
The assertions take io_sel and hi_sel as never both high. If both are high, the I/O window wins, and the load-slot checks do not describe that case. They also take rd_en and wr_en as never active together. The bench drives only one select and one strobe at a time, and changes them on the falling clock edge. It enters compatibility mode only in its last scenario, and then applies reset again.

// File: rtl/bankcfg_pkg.sv
// Shared constants and helpers for the banking configuration register file.
// Assumes an 8-bit data path and four presets.
package bankcfg_pkg;
    localparam int DW = 8;
    localparam logic [DW-1:0] MODE_RESET   = 8'hBF;
    localparam logic [DW-1:0] MODE_FORCE   = 8'h06;
    localparam logic [DW-1:0] VERSION_CODE = 8'h20;
    localparam logic [DW-1:0] UNUSED_READ  = 8'hFF;

    // Reset value of preset i.
    function automatic logic [DW-1:0] preset_init(input int i);
        case (i)
            0:       return 8'h3F;
            1:       return 8'h7F;
            2:       return 8'h01;
            default: return 8'h41;
        endcase
    endfunction
endpackage

// File: rtl/bankcfg_presets.sv
// Bank of preset configuration bytes, one write enable per byte.
// Assumes at most one enable is high in any cycle.
module bankcfg_presets #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          we,
    input  logic [DW-1:0]         wdata,
    output logic [N-1:0][DW-1:0]  q
);
    for (genvar i = 0; i < N; i++) begin : g_preset
        // Holds one preset byte.
        always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= DW'(bankcfg_pkg::preset_init(i));
            else if (we[i]) q[i] <= wdata;
        end
    end

    // R3
    preset_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(we));
endmodule

// File: rtl/bankcfg_mode.sv
// Mode byte: forced bits, key-gated bit 7, decoded control outputs.
// Assumes key_in is already synchronised to clk.
module bankcfg_mode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       key_in,
    output logic [7:0] rd_val,
    output logic       compat,
    output logic       cpu_alt_req,
    output logic       ext_a,
    output logic       ext_b,
    output logic       fs_dir
);
    import bankcfg_pkg::*;
    logic [7:0] mode_q;

    // Stores the mode byte with the always-set bits forced.
    always_ff @(posedge clk) begin
        if (!rst_n)  mode_q <= MODE_RESET;
        else if (we) mode_q <= wdata | MODE_FORCE;
    end

    // Forms the read value and the decoded outputs.
    always_comb begin
        rd_val      = {mode_q[7] & key_in, mode_q[6:0]};
        compat      = mode_q[6];
        cpu_alt_req = ~mode_q[0];
        ext_a       = mode_q[5];
        ext_b       = mode_q[4];
        fs_dir      = mode_q[3];
    end

    // R7
    key_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[7]) |=> !rd_val[7]);
endmodule

// File: rtl/bankcfg_regs.sv
// Top of the configuration register file. Decodes the two windows,
// performs load-slot copies and drives the read mux and field outputs.
// Assumes io_sel and hi_sel are never both high (I/O wins if they are).
module bankcfg_regs #(
    parameter int AW = 8,
    parameter int NPRE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          io_sel,
    input  logic          hi_sel,
    input  logic          key_in,
    output logic [7:0]    rdata,
    output logic [1:0]    ram_bank,
    output logic [1:0]    hi_area,
    output logic [1:0]    mid_area,
    output logic          lo_area,
    output logic          io_off,
    output logic          compat,
    output logic          cpu_alt_req,
    output logic          ext_a,
    output logic          ext_b,
    output logic          fs_dir,
    output logic [1:0]    video_bank,
    output logic [1:0]    ram_block,
    output logic          share_top,
    output logic          share_bottom,
    output logic [1:0]    share_size
);
    import bankcfg_pkg::*;
    localparam int IDXW = $clog2(NPRE);
    localparam logic [AW-1:0] OFF_CR   = '0;
    localparam logic [AW-1:0] OFF_P0   = AW'(1);
    localparam logic [AW-1:0] OFF_PN   = AW'(NPRE);
    localparam logic [AW-1:0] OFF_MODE = AW'(NPRE + 1);
    localparam logic [AW-1:0] OFF_RAM  = AW'(NPRE + 2);
    localparam logic [AW-1:0] OFF_VER  = AW'(NPRE + 7);

    logic [7:0]            cr_q, ram_q, mode_rd;
    logic [NPRE-1:0][7:0]  preset_q;
    logic [NPRE-1:0]       preset_we;
    logic                  io_act, hi_act, io_wr, hi_wr, slot_hit, mode_we;
    logic [IDXW-1:0]       slot_idx;

    // Window gating and offset decode.
    always_comb begin
        io_act   = io_sel & ~compat;
        hi_act   = hi_sel & ~io_sel & ~compat;
        io_wr    = io_act & wr_en;
        hi_wr    = hi_act & wr_en;
        slot_hit = (addr >= OFF_P0) && (addr <= OFF_PN);
        slot_idx = IDXW'(addr - OFF_P0);
        mode_we  = io_wr && (addr == OFF_MODE);
        for (int i = 0; i < NPRE; i++)
            preset_we[i] = io_wr && (addr == AW'(i + 1));
    end

    // Active configuration byte: direct writes from either window or load-slot copy.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cr_q <= '0;
        else if ((io_wr || hi_wr) && addr == OFF_CR) cr_q <= wdata;
        else if (hi_wr && slot_hit)                 cr_q <= preset_q[slot_idx];
    end

    // RAM configuration byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                         ram_q <= '0;
        else if (io_wr && addr == OFF_RAM)  ram_q <= wdata;
    end

    bankcfg_presets #(.N(NPRE), .DW(8)) u_presets (
        .clk(clk), .rst_n(rst_n), .we(preset_we), .wdata(wdata), .q(preset_q)
    );

    bankcfg_mode u_mode (
        .clk(clk), .rst_n(rst_n), .we(mode_we), .wdata(wdata), .key_in(key_in),
        .rd_val(mode_rd), .compat(compat), .cpu_alt_req(cpu_alt_req),
        .ext_a(ext_a), .ext_b(ext_b), .fs_dir(fs_dir)
    );

    // Read mux for both windows.
    always_comb begin
        rdata = '0;
        if (rd_en && io_act) begin
            if (addr == OFF_CR)        rdata = cr_q;
            else if (slot_hit)         rdata = preset_q[slot_idx];
            else if (addr == OFF_MODE) rdata = mode_rd;
            else if (addr == OFF_RAM)  rdata = ram_q;
            else if (addr == OFF_VER)  rdata = VERSION_CODE;
            else                       rdata = UNUSED_READ;
        end else if (rd_en && hi_act) begin
            if (addr == OFF_CR)        rdata = cr_q;
            else if (slot_hit)         rdata = preset_q[slot_idx];
        end
    end

    // Field outputs for the mapping logic.
    always_comb begin
        {ram_bank, hi_area, mid_area, lo_area, io_off}              = cr_q;
        {video_bank, ram_block, share_top, share_bottom, share_size} = ram_q;
    end

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_sel && !io_sel && wr_en && !compat && slot_hit) |=> (cr_q == $past(preset_q[slot_idx])));
    // R4
    load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_sel && !io_sel && wr_en) |=> $stable(preset_q));
    // R6
    compat_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compat && wr_en) |=> ($stable(cr_q) && $stable(ram_q) && $stable(preset_q)));
    // R6
    compat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        compat |-> (rdata == 8'h00));
    // R8
    version_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && rd_en && !compat && addr == OFF_VER) |-> (rdata == 8'h20));
    // R5
    mode_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && rd_en && !compat && addr == OFF_MODE) |-> (rdata[2:1] == 2'b11));
    // R12
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |-> (rdata == 8'h00));
endmodule

// File: tb/bankcfg_regs_bench.sv
// Directed bench for bankcfg_regs: one task per scenario.
module bankcfg_regs_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] addr = '0, wdata = '0, rdata;
    logic wr_en = 0, rd_en = 0, io_sel = 0, hi_sel = 0, key_in = 1;
    logic [1:0] ram_bank, hi_area, mid_area, video_bank, ram_block, share_size;
    logic lo_area, io_off, compat, cpu_alt_req, ext_a, ext_b, fs_dir, share_top, share_bottom;
    int checks = 0, failures = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    bankcfg_regs u_bankcfg_regs (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit hi, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_sel = !hi; hi_sel = hi; addr = a; wdata = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0; io_sel = 0; hi_sel = 0;
    endtask

    task automatic rd(input bit hi, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_sel = !hi; hi_sel = hi; addr = a; rd_en = 1;
        #1 d = rdata;
        rd_en = 0; io_sel = 0; hi_sel = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        rd(0, 0, rv); check("R1 cr", rv, 8'h00);
        rd(0, 1, rv); check("R1 p0", rv, 8'h3F);
        rd(0, 2, rv); check("R1 p1", rv, 8'h7F);
        rd(0, 3, rv); check("R1 p2", rv, 8'h01);
        rd(0, 4, rv); check("R1 p3", rv, 8'h41);
        rd(0, 5, rv); check("R1 mode", rv, 8'hBF);
        rd(0, 6, rv); check("R1 ram", rv, 8'h00);
    endtask

    task automatic t_cr_windows();
        wr(0, 0, 8'h3F); rd(1, 0, rv); check("R2 io->hi", rv, 8'h3F);
        wr(1, 0, 8'hA5); rd(0, 0, rv); check("R2 hi->io", rv, 8'hA5);
        check("R11 fields", {ram_bank, hi_area, mid_area, lo_area, io_off}, 8'hA5);
    endtask

    task automatic t_presets();
        wr(0, 2, 8'h5A); rd(0, 2, rv); check("R3 p1 rw", rv, 8'h5A);
        rd(0, 4, rv); check("R3 p3 kept", rv, 8'h41);
    endtask

    task automatic t_load_slots();
        rd(1, 1, rv); check("R4 slot1 read", rv, 8'h3F);
        rd(1, 2, rv); check("R4 slot2 read", rv, 8'h5A);
        wr(1, 3, 8'hEE); rd(0, 0, rv); check("R4 slot3 copy", rv, 8'h01);
        rd(0, 3, rv); check("R4 preset unchanged", rv, 8'h01);
        wr(1, 2, 8'h00); rd(1, 0, rv); check("R4 slot2 copy", rv, 8'h5A);
        check("R11 after copy", {ram_bank, hi_area, mid_area, lo_area, io_off}, 8'h5A);
    endtask

    task automatic t_mode();
        wr(0, 5, 8'h01); rd(0, 5, rv); check("R5 forced bits", rv, 8'h07);
        check("R5 cpu_alt_req low", {7'd0, cpu_alt_req}, 8'h00);
        wr(0, 5, 8'hB0); rd(0, 5, rv); check("R5 readback", rv, 8'hB6);
        check("R5 decoded", {4'd0, cpu_alt_req, ext_a, ext_b, fs_dir}, 8'h0E);
        wr(0, 5, 8'hB9); rd(0, 5, rv); check("R5 restore", rv, 8'hBF);
    endtask

    task automatic t_key();
        key_in = 0; rd(0, 5, rv); check("R7 key pressed", rv, 8'h3F);
        key_in = 1; rd(0, 5, rv); check("R7 key released", rv, 8'hBF);
        wr(0, 5, 8'h3F); rd(0, 5, rv); check("R7 cleared", rv, 8'h3F);
        wr(0, 5, 8'hBF); rd(0, 5, rv); check("R7 set again", rv, 8'hBF);
    endtask

    task automatic t_version_unused();
        rd(0, 11, rv); check("R8 version", rv, 8'h20);
        wr(0, 11, 8'h00); rd(0, 11, rv); check("R8 read-only", rv, 8'h20);
        rd(0, 7, rv); check("R9 off7", rv, 8'hFF);
        rd(0, 12, rv); check("R9 off12", rv, 8'hFF);
        rd(0, 255, rv); check("R9 off255", rv, 8'hFF);
        wr(0, 200, 8'h00); rd(0, 0, rv); check("R9 write ignored cr", rv, 8'h5A);
        rd(0, 6, rv); check("R9 write ignored ram", rv, 8'h00);
    endtask

    task automatic t_ramcfg();
        wr(0, 6, 8'hC9); rd(0, 6, rv); check("R10 readback", rv, 8'hC9);
        check("R10 fields", {video_bank, ram_block, share_top, share_bottom, share_size}, 8'hC9);
    endtask

    task automatic t_idle();
        @(negedge clk); io_sel = 1; addr = 0; #1 check("R12 no strobe", rdata, 8'h00); io_sel = 0;
        @(negedge clk); rd_en = 1; #1 check("R12 no select", rdata, 8'h00); rd_en = 0;
        rd(1, 7, rv); check("R12 hi offset 7", rv, 8'h00);
    endtask

    task automatic t_compat();
        wr(0, 0, 8'hA5);
        wr(0, 5, 8'hFF);
        check("R6 compat out", {7'd0, compat}, 8'h01);
        rd(0, 0, rv); check("R6 io read zero", rv, 8'h00);
        rd(1, 1, rv); check("R6 hi read zero", rv, 8'h00);
        wr(0, 0, 8'h12); wr(1, 1, 8'h00); wr(0, 6, 8'h00);
        check("R6 cr frozen", {ram_bank, hi_area, mid_area, lo_area, io_off}, 8'hA5);
        check("R6 ram frozen", {video_bank, ram_block, share_top, share_bottom, share_size}, 8'hC9);
        do_reset();
        check("R1 compat cleared", {7'd0, compat}, 8'h00);
        t_reset();
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_cr_windows();
        t_presets();
        t_load_slots();
        t_mode();
        t_key();
        t_version_unused();
        t_ramcfg();
        t_idle();
        t_compat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule